// File: doc/BRIEF.md
# Counting Semaphore Unit

This block holds one counting semaphore shared by a producer and several consumers. The producer raises a put request to add one unit to the count. Each consumer has its own get port and raises a get request, with a timeout, to take one unit. Every request that completes gives a one-cycle done pulse and a 4-bit result code.

A get that finds no unit does not fail at once. It parks in a wait slot for that port and counts down its timeout on each timebase tick pulse. It completes when a unit appears or when its tick budget runs out. A put that would push the count past its ceiling is refused with an overflow code, and the count is left as it was.

All requests seen in one cycle are resolved together, so no increment or decrement is lost. Consumers are ranked by port index, and port 0 ranks highest. The count is 8 bits wide and its ceiling is 255.

Top module: `count_sem_unit`

## Requirements
- R1: After reset the count is 0, no done pulse is raised and no get port is waiting.
- R2: A put with the count below 255 adds one to the count and, one cycle later, pulses put_done with code 0.
- R3: A put with the count at 255 and no get taking a unit in that cycle leaves the count at 255 and pulses put_done with code 14 (overflow).
- R4: A get with a unit available takes one unit and, one cycle later, pulses its get_done with code 0 (success).
- R5: A get that finds the count at 0 waits. A later put completes it with code 0 in the cycle after the count becomes nonzero, and the count returns to 0.
- R6: A waiting get loads its budget from its timeout and lowers the budget by one on each tick pulse while the count stays at 0. On the tick that exhausts the budget it completes with code 1 (timeout) and leaves the count unchanged. Cycles without a tick do not advance the budget.
- R7: A get with timeout 0 that finds no unit completes with code 1 one cycle later, without waiting for a tick.
- R8: A put and a get in the same cycle are both applied, so the count does not change. This holds at the ceiling of 255, where the put reports code 0.
- R9: Gets in the same cycle are served in port order, lowest index first, up to the number of units held. A port left without a unit starts to wait.
- R10: When waiting ports see the count become nonzero but the units go to higher-ranked ports, each port left without a unit completes with code 15 (empty on re-check).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse, one cycle wide |
| put_req | input | 1 | Producer put request, one cycle |
| put_done | output | 1 | Put completed, one-cycle pulse |
| put_code | output | 4 | Put result: 0 ok, 14 overflow |
| get_req | input | NUM_GET | Per-port get request, one cycle, ignored while that port waits |
| get_tmo | input | NUM_GET*TMO_W | Per-port timeout in ticks, taken with the request |
| get_done | output | NUM_GET | Per-port get completed, one-cycle pulse |
| get_code | output | NUM_GET*4 | Per-port result: 0 ok, 1 timeout, 15 empty |
| count | output | CNT_W | Current semaphore count |

## Verification
Every result leaves a register, so a put or get that resolves right away shows its done pulse and code one cycle after the request is taken. The count shows its new value in that same cycle. A waiting get resolves one cycle after the clock edge that sees a tick on its last budget unit, or a nonzero count. The bench changes inputs on the falling edge and reads outputs on the next falling edge. This puts each check in the exact cycle its result is due. Waits are checked with no done pulse in the cycles before that.

// File: rtl/sem_pkg.sv
// Package: result codes and widths shared by the semaphore unit modules.
package sem_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        SEM_OK       = 4'd0,
        SEM_TIMEOUT  = 4'd1,
        SEM_OVERFLOW = 4'd14,
        SEM_EMPTY    = 4'd15
    } sem_code_e;
endpackage

// File: rtl/sem_grant_arb.sv
// Grant arbiter: hands the units in the current count to the requesting
// get ports in fixed priority order, port 0 first.
// Assumes: count is the registered count; 'want' is the combinational
// demand from each waiter slot. Purely combinational apart from the checks.
module sem_grant_arb #(
    parameter int NUM_GET = 2,
    parameter int CNT_W   = 8,
    parameter int GW      = $clog2(NUM_GET + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   count,
    input  logic [NUM_GET-1:0] want,
    output logic [NUM_GET-1:0] grant,
    output logic [GW-1:0]      n_grant
);
    logic [CNT_W-1:0] left;

    // Walk the ports by rank, granting while units remain.
    always_comb begin
        left    = count;
        grant   = '0;
        n_grant = '0;
        for (int i = 0; i < NUM_GET; i++) begin
            if (want[i] && left != '0) begin
                grant[i] = 1'b1;
                left     = left - 1'b1;
                n_grant  = n_grant + 1'b1;
            end
        end
    end

    // R9: never more grants than units held, and only to ports that asked.
    assert_grant_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(grant) <= count) && ((grant & ~want) == '0));

    // R9: port 0 asking with a unit held is always served.
    assert_port0_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (want[0] && count != '0) |-> grant[0]);
endmodule

// File: rtl/sem_count_reg.sv
// Count register: holds the semaphore count, applies the units granted to
// gets and the producer put in the same cycle, and reports the put result.
// Assumes: n_grant never exceeds count (guaranteed by the arbiter).
module sem_count_reg
    import sem_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int MAX_CNT = 255,
    parameter int GW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put_req,
    input  logic [GW-1:0]     n_grant,
    output logic [CNT_W-1:0]  count,
    output logic              put_done,
    output logic [CODE_W-1:0] put_code
);
    localparam logic [CNT_W-1:0] CEIL = CNT_W'(MAX_CNT);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] after_get;
    logic             put_ok;

    // Count after this cycle's grants; the put is judged against it.
    always_comb begin
        after_get = count_q - CNT_W'(n_grant);
        put_ok    = put_req && (after_get < CEIL);
    end

    // Update the count and register the put result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            put_done <= 1'b0;
            put_code <= SEM_OK;
        end else begin
            count_q  <= after_get + (put_ok ? CNT_W'(1) : CNT_W'(0));
            put_done <= put_req;
            put_code <= put_ok ? SEM_OK : SEM_OVERFLOW;
        end
    end

    assign count = count_q;

    // R3: the count never exceeds its ceiling.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CEIL);

    // R3: a refused put at the ceiling leaves the count in place.
    assert_ceiling_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (put_req && count_q == CEIL && n_grant == '0) |=> (count_q == CEIL));

    // R2: a lone put below the ceiling adds exactly one.
    assert_put_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (put_req && count_q < CEIL && n_grant == '0) |=>
        (count_q == $past(count_q) + 1'b1));

    // R8: put and a single grant together leave the count unchanged.
    assert_net_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (put_req && n_grant == GW'(1)) |=> $stable(count_q));
endmodule

// File: rtl/sem_waiter.sv
// Waiter slot: one per get port. Takes a request, claims a unit through the
// arbiter, or parks and counts down its tick budget until a unit shows up
// or the budget is spent. Produces the per-port done pulse and code.
// Assumes: tick is a one-cycle pulse; requests while parked are ignored.
module sem_waiter
    import sem_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic [TMO_W-1:0]  tmo,
    input  logic              grant,
    input  logic              cnt_nz,
    output logic              want,
    output logic              done,
    output logic [CODE_W-1:0] code
);
    logic             waiting_q;
    logic [TMO_W-1:0] budget_q;

    // Demand a unit on a fresh request or every cycle while parked.
    assign want = waiting_q || req;

    // Slot state: idle/parked, tick budget, and the registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
            budget_q  <= '0;
            done      <= 1'b0;
            code      <= SEM_OK;
        end else begin
            done <= 1'b0;
            if (!waiting_q) begin
                if (req) begin
                    if (grant) begin
                        done <= 1'b1;
                        code <= SEM_OK;
                    end else if (tmo == '0) begin
                        done <= 1'b1;
                        code <= SEM_TIMEOUT;
                    end else begin
                        waiting_q <= 1'b1;
                        budget_q  <= tmo;
                    end
                end
            end else if (grant) begin
                done      <= 1'b1;
                code      <= SEM_OK;
                waiting_q <= 1'b0;
            end else if (cnt_nz) begin
                done      <= 1'b1;
                code      <= SEM_EMPTY;
                waiting_q <= 1'b0;
            end else if (tick) begin
                if (budget_q == TMO_W'(1)) begin
                    done      <= 1'b1;
                    code      <= SEM_TIMEOUT;
                    waiting_q <= 1'b0;
                end else begin
                    budget_q <= budget_q - 1'b1;
                end
            end
        end
    end

    // R4: a success is only reported after a unit was granted.
    assert_ok_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && code == SEM_OK) |-> $past(grant));

    // R6: a parked slot with no unit and no tick stays silent.
    assert_no_tick_no_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_q && !cnt_nz && !tick) |=> !done);

    // R7: zero timeout on an empty count ends at once with timeout.
    assert_zero_tmo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting_q && req && !grant && tmo == '0) |=> (done && code == SEM_TIMEOUT));

    // R10: a parked slot that sees units but wins none reports empty.
    assert_lost_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_q && cnt_nz && !grant) |=> (done && code == SEM_EMPTY));
endmodule

// File: rtl/count_sem_unit.sv
// Counting semaphore unit top: one producer put port, NUM_GET consumer get
// ports with tick-counted waits. Wires the waiter slots, the priority grant
// arbiter and the count register together.
// Assumes: synchronous active-low reset; tick and requests are one cycle.
module count_sem_unit
    import sem_pkg::*;
#(
    parameter int NUM_GET = 2,
    parameter int CNT_W   = 8,
    parameter int MAX_CNT = 255,
    parameter int TMO_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      put_req,
    output logic                      put_done,
    output logic [CODE_W-1:0]         put_code,
    input  logic [NUM_GET-1:0]        get_req,
    input  logic [NUM_GET*TMO_W-1:0]  get_tmo,
    output logic [NUM_GET-1:0]        get_done,
    output logic [NUM_GET*CODE_W-1:0] get_code,
    output logic [CNT_W-1:0]          count
);
    localparam int GW = $clog2(NUM_GET + 1);

    logic [NUM_GET-1:0] want;
    logic [NUM_GET-1:0] grant;
    logic [GW-1:0]      n_grant;
    logic               cnt_nz;

    assign cnt_nz = (count != '0);

    sem_grant_arb #(.NUM_GET(NUM_GET), .CNT_W(CNT_W), .GW(GW)) arb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .want    (want),
        .grant   (grant),
        .n_grant (n_grant)
    );

    sem_count_reg #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT), .GW(GW)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .put_req  (put_req),
        .n_grant  (n_grant),
        .count    (count),
        .put_done (put_done),
        .put_code (put_code)
    );

    for (genvar g = 0; g < NUM_GET; g++) begin : g_slot
        sem_waiter #(.TMO_W(TMO_W)) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .req    (get_req[g]),
            .tmo    (get_tmo[g*TMO_W +: TMO_W]),
            .grant  (grant[g]),
            .cnt_nz (cnt_nz),
            .want   (want[g]),
            .done   (get_done[g]),
            .code   (get_code[g*CODE_W +: CODE_W])
        );
    end

    // R1: the first cycle after reset shows an empty, quiet unit.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (count == '0 && !put_done && get_done == '0));
endmodule

// File: tb/count_sem_unit_tb.sv
// Directed bench for count_sem_unit: one task per scenario.
module count_sem_unit_tb_top;
    localparam int NG = 2;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          put_req = 1'b0;
    logic          put_done;
    logic [3:0]    put_code;
    logic [NG-1:0] get_req = '0;
    logic [NG*TW-1:0] get_tmo = '0;
    logic [NG-1:0] get_done;
    logic [NG*4-1:0] get_code;
    logic [7:0]    count;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    count_sem_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .put_req(put_req), .put_done(put_done), .put_code(put_code),
        .get_req(get_req), .get_tmo(get_tmo),
        .get_done(get_done), .get_code(get_code), .count(count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    function automatic int gcode(input int i);
        return int'(get_code[i*4 +: 4]);
    endfunction

    // Drive one cycle of inputs from a falling edge; outputs valid on return.
    task automatic cyc(input bit p, input bit [NG-1:0] g, input int t0, input int t1, input bit tk);
        put_req = p;
        get_req = g;
        get_tmo = {TW'(t1), TW'(t0)};
        tick    = tk;
        @(negedge clk);
        put_req = 1'b0;
        get_req = '0;
        tick    = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fill(input int n);
        for (int k = 0; k < n; k++) cyc(1'b1, '0, 0, 0, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        chk_eq("R1 count", count, 0);
        chk_eq("R1 put_done", put_done, 0);
        chk_eq("R1 get_done", get_done, 0);
    endtask

    task automatic t_put();
        do_reset();
        for (int k = 1; k <= 3; k++) begin
            cyc(1'b1, '0, 0, 0, 1'b0);
            chk_eq("R2 put_done", put_done, 1);
            chk_eq("R2 put_code", put_code, 0);
            chk_eq("R2 count", count, k);
        end
    endtask

    task automatic t_overflow();
        do_reset();
        fill(255);
        chk_eq("R3 count at ceiling", count, 255);
        cyc(1'b1, '0, 0, 0, 1'b0);
        chk_eq("R3 put_code", put_code, 14);
        chk_eq("R3 count held", count, 255);
    endtask

    task automatic t_get();
        do_reset();
        fill(2);
        cyc(1'b0, 2'b01, 5, 0, 1'b0);
        chk_eq("R4 get_done", get_done, 2'b01);
        chk_eq("R4 get_code", gcode(0), 0);
        chk_eq("R4 count", count, 1);
    endtask

    task automatic t_wait_put();
        do_reset();
        cyc(1'b0, 2'b01, 10, 0, 1'b0);
        chk_eq("R5 parked", get_done, 0);
        cyc(1'b0, '0, 0, 0, 1'b1);
        cyc(1'b0, '0, 0, 0, 1'b1);
        chk_eq("R5 still parked", get_done, 0);
        cyc(1'b1, '0, 0, 0, 1'b0);
        chk_eq("R5 put accepted count", count, 1);
        chk_eq("R5 not yet done", get_done, 0);
        cyc(1'b0, '0, 0, 0, 1'b0);
        chk_eq("R5 get_done", get_done, 2'b01);
        chk_eq("R5 get_code", gcode(0), 0);
        chk_eq("R5 count", count, 0);
    endtask

    task automatic t_timeout();
        do_reset();
        cyc(1'b0, 2'b01, 3, 0, 1'b0);
        cyc(1'b0, '0, 0, 0, 1'b1);
        cyc(1'b0, '0, 0, 0, 1'b0);
        cyc(1'b0, '0, 0, 0, 1'b0);
        cyc(1'b0, '0, 0, 0, 1'b1);
        chk_eq("R6 no end after 2 ticks", get_done, 0);
        cyc(1'b0, '0, 0, 0, 1'b1);
        chk_eq("R6 get_done", get_done, 2'b01);
        chk_eq("R6 get_code", gcode(0), 1);
        chk_eq("R6 count", count, 0);
    endtask

    task automatic t_tmo_zero();
        do_reset();
        cyc(1'b0, 2'b10, 0, 0, 1'b0);
        chk_eq("R7 get_done", get_done, 2'b10);
        chk_eq("R7 get_code", gcode(1), 1);
    endtask

    task automatic t_simul();
        do_reset();
        fill(5);
        cyc(1'b1, 2'b01, 4, 0, 1'b0);
        chk_eq("R8 count mid", count, 5);
        chk_eq("R8 put_code mid", put_code, 0);
        fill(250);
        cyc(1'b1, 2'b01, 4, 0, 1'b0);
        chk_eq("R8 count ceiling", count, 255);
        chk_eq("R8 put_code ceiling", put_code, 0);
        chk_eq("R8 get_code ceiling", gcode(0), 0);
    endtask

    task automatic t_two_gets();
        do_reset();
        fill(2);
        cyc(1'b0, 2'b11, 4, 4, 1'b0);
        chk_eq("R9 both done", get_done, 2'b11);
        chk_eq("R9 count drained", count, 0);
        fill(1);
        cyc(1'b0, 2'b11, 4, 4, 1'b0);
        chk_eq("R9 port0 served", get_done, 2'b01);
        chk_eq("R9 port0 code", gcode(0), 0);
        for (int k = 0; k < 4; k++) cyc(1'b0, '0, 0, 0, 1'b1);
        chk_eq("R9 port1 waited out", get_done, 2'b10);
        chk_eq("R9 port1 code", gcode(1), 1);
    endtask

    task automatic t_wake_race();
        do_reset();
        cyc(1'b0, 2'b11, 8, 8, 1'b0);
        chk_eq("R10 both parked", get_done, 0);
        cyc(1'b1, '0, 0, 0, 1'b0);
        cyc(1'b0, '0, 0, 0, 1'b0);
        chk_eq("R10 both end", get_done, 2'b11);
        chk_eq("R10 port0 code", gcode(0), 0);
        chk_eq("R10 port1 code", gcode(1), 15);
        chk_eq("R10 count", count, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_put();
        t_overflow();
        t_get();
        t_wait_put();
        t_timeout();
        t_tmo_zero();
        t_simul();
        t_two_gets();
        t_wake_race();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule